// File: doc/BRIEF.md
# Packed Saturating Lane Arithmetic Unit

This block performs lane-wise arithmetic on a 32-bit word split into packed lanes. It has two lane layouts. In the first, the word holds four unsigned bytes. In the second, it holds two signed 16-bit fixed-point fractions in Q15 format, covering -1 up to just below +1. For each lane the unit can add, subtract, shift left or shift right. No carry or borrow ever crosses from one lane into the next.

When saturation is on, a lane that leaves its range is clamped to the nearest value that lane can hold. When saturation is off, the lane wraps modulo its width. In both cases a per-lane overflow mask reports the event, and a sticky flag collects overflows until a clear input resets it.

Operands are accepted on a cycle with `in_valid` high. The packed result and the mask are registered and appear one clock later. A two-state output sequencer drives `res_valid`:
- In `S_IDLE`, no fresh result is present. It moves to `S_RESULT` on any cycle with `in_valid` high.
- In `S_RESULT`, a fresh result is present. It stays there while `in_valid` remains high and returns to `S_IDLE` otherwise.

Top module: `simd_satalu`

## Requirements
- R1: A word presented with `in_valid` high produces `result` and `ovf_mask` on the next clock, with `res_valid` high for exactly that cycle. Without `in_valid`, `res_valid` is low and `result` and `ovf_mask` hold their values.
- R2: After reset, `res_valid`, `result`, `ovf_mask` and `sticky_ovf` are all zero.
- R3: With `lane_mode`=0 (byte lanes, byte i = bits 8i+7:8i, mask bit i) and `op_sel`=00 (add), each byte is the unsigned sum with no carry into the next byte. An unsigned overflow sets mask bit i and, when `sat_en`=1, gives 0xFF.
- R4: With byte lanes and `op_sel`=01 (subtract a minus b), a borrow in byte i sets mask bit i and, when `sat_en`=1, gives 0x00.
- R5: With `lane_mode`=1 (Q15 lanes, lane i = bits 16i+15:16i, mask bit i, mask bits 3:2 always zero), add (00) and subtract (01) are signed. A signed overflow sets the mask bit and, when saturating, clamps to 0x7FFF above the range or 0x8000 below it.
- R6: `op_sel`=10 shifts each lane left by `opb[2:0]` (byte lanes) or `opb[3:0]` (Q15 lanes). If significant bits are lost (any set bit for bytes, a change of sign extension for Q15), the mask bit is set and, when saturating, the lane becomes 0xFF, or 0x7FFF/0x8000 according to the operand sign.
- R7: `op_sel`=11 shifts right by the same amount. Byte lanes fill with zeros, Q15 lanes fill with copies of the sign bit, and the mask bit is never set.
- R8: With `sat_en`=0, every overflowing lane holds its wrapped value, modulo 2^8 or 2^16, and the mask still reports the overflow.
- R9: `sticky_ovf` becomes 1 at the edge that captures any nonzero mask and stays 1 until an edge with `sticky_clr` high. If a clear and a new overflow meet at the same edge, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| lane_mode | input | 1 | 0: four unsigned bytes, 1: two signed Q15 halves |
| op_sel | input | 2 | 00 add, 01 subtract, 10 shift left, 11 shift right |
| sat_en | input | 1 | Clamp overflowing lanes instead of wrapping |
| opa | input | 32 | First packed operand |
| opb | input | 32 | Second packed operand; low bits give the shift amount |
| sticky_clr | input | 1 | Clears the sticky overflow flag |
| res_valid | output | 1 | Registered result is fresh this cycle |
| result | output | 32 | Packed lane result |
| ovf_mask | output | 4 | Per-lane overflow mask |
| sticky_ovf | output | 1 | Accumulated overflow flag |

## Verification
Clearing the sticky flag and capturing a new lane overflow can happen at the same edge. The bench provokes this by asserting `sticky_clr` together with an operation that overflows. It checks that the flag remains set, and it also checks the opposite case, where a clear paired with a clean operation drops the flag. Each lane result is compared with a per-lane integer model in the bench, with saturation both on and off, so that an overflow in one lane cannot be hidden by a carry leaking into its neighbour.

// File: rtl/simd_pkg.sv
package simd_pkg;
    typedef enum logic {
        LM_BYTE = 1'b0,
        LM_HALF = 1'b1
    } lane_mode_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_SHL = 2'b10,
        OP_SHR = 2'b11
    } lane_op_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_RESULT = 1'b1
    } out_state_e;
endpackage

// File: rtl/simd_ulane.sv
// Unsigned lane: add, subtract, shifts with optional clamp to [0, 2^W-1].
module simd_ulane
    import simd_pkg::*;
#(
    parameter int W = 8,
    localparam int SH_W = $clog2(W)
) (
    input  lane_op_e        op,
    input  logic            sat_en,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [SH_W-1:0] shamt,
    output logic [W-1:0]    y,
    output logic            ovf
);
    localparam logic [W-1:0] MAX_V = '1;

    logic [W:0]     ext_sum;
    logic [W:0]     ext_dif;
    logic [2*W-1:0] wide_shl;

    always_comb begin
        ext_sum  = {1'b0, a} + {1'b0, b};
        ext_dif  = {1'b0, a} - {1'b0, b};
        wide_shl = {{W{1'b0}}, a} << shamt;
        unique case (op)
            OP_ADD: begin
                ovf = ext_sum[W];
                y   = (ovf && sat_en) ? MAX_V : ext_sum[W-1:0];
            end
            OP_SUB: begin
                ovf = ext_dif[W];
                y   = (ovf && sat_en) ? '0 : ext_dif[W-1:0];
            end
            OP_SHL: begin
                ovf = |wide_shl[2*W-1:W];
                y   = (ovf && sat_en) ? MAX_V : wide_shl[W-1:0];
            end
            OP_SHR: begin
                ovf = 1'b0;
                y   = a >> shamt;
            end
        endcase
    end
endmodule

// File: rtl/simd_slane.sv
// Signed lane: add, subtract, shifts with optional clamp to the signed range.
module simd_slane
    import simd_pkg::*;
#(
    parameter int W = 16,
    localparam int SH_W = $clog2(W)
) (
    input  lane_op_e        op,
    input  logic            sat_en,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [SH_W-1:0] shamt,
    output logic [W-1:0]    y,
    output logic            ovf
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]     ext_sum;
    logic [W:0]     ext_dif;
    logic [2*W-1:0] wide_shl;
    logic [W:0]     top_bits;

    always_comb begin
        ext_sum  = {a[W-1], a} + {b[W-1], b};
        ext_dif  = {a[W-1], a} - {b[W-1], b};
        wide_shl = {{W{a[W-1]}}, a} << shamt;
        top_bits = wide_shl[2*W-1:W-1];
        unique case (op)
            OP_ADD: begin
                ovf = ext_sum[W] ^ ext_sum[W-1];
                y   = !(ovf && sat_en) ? ext_sum[W-1:0]
                    : (ext_sum[W] ? NEG_MIN : POS_MAX);
            end
            OP_SUB: begin
                ovf = ext_dif[W] ^ ext_dif[W-1];
                y   = !(ovf && sat_en) ? ext_dif[W-1:0]
                    : (ext_dif[W] ? NEG_MIN : POS_MAX);
            end
            OP_SHL: begin
                ovf = !((&top_bits) || !(|top_bits));
                y   = !(ovf && sat_en) ? wide_shl[W-1:0]
                    : (a[W-1] ? NEG_MIN : POS_MAX);
            end
            OP_SHR: begin
                ovf = 1'b0;
                y   = W'($signed(a) >>> shamt);
            end
        endcase
    end
endmodule

// File: rtl/simd_satalu.sv
module simd_satalu
    import simd_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BYTE_W = 8,
    localparam int HALF_W = 16,
    localparam int BYTE_LANES = DATA_W / BYTE_W,
    localparam int HALF_LANES = DATA_W / HALF_W,
    localparam int BSH_W = $clog2(BYTE_W),
    localparam int HSH_W = $clog2(HALF_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  lane_mode,
    input  logic [1:0]            op_sel,
    input  logic                  sat_en,
    input  logic [DATA_W-1:0]     opa,
    input  logic [DATA_W-1:0]     opb,
    input  logic                  sticky_clr,
    output logic                  res_valid,
    output logic [DATA_W-1:0]     result,
    output logic [BYTE_LANES-1:0] ovf_mask,
    output logic                  sticky_ovf
);
    lane_op_e   op_e;
    lane_mode_e mode_e;
    out_state_e state_q, state_d;

    logic [DATA_W-1:0]     byte_y, half_y, next_y;
    logic [BYTE_LANES-1:0] byte_ovf, next_ovf;
    logic [HALF_LANES-1:0] half_ovf;

    assign op_e   = lane_op_e'(op_sel);
    assign mode_e = lane_mode_e'(lane_mode);

    for (genvar i = 0; i < BYTE_LANES; i++) begin : g_byte
        simd_ulane #(.W(BYTE_W)) u_lane (
            .op     (op_e),
            .sat_en (sat_en),
            .a      (opa[i*BYTE_W +: BYTE_W]),
            .b      (opb[i*BYTE_W +: BYTE_W]),
            .shamt  (opb[BSH_W-1:0]),
            .y      (byte_y[i*BYTE_W +: BYTE_W]),
            .ovf    (byte_ovf[i])
        );
    end

    for (genvar j = 0; j < HALF_LANES; j++) begin : g_half
        simd_slane #(.W(HALF_W)) u_lane (
            .op     (op_e),
            .sat_en (sat_en),
            .a      (opa[j*HALF_W +: HALF_W]),
            .b      (opb[j*HALF_W +: HALF_W]),
            .shamt  (opb[HSH_W-1:0]),
            .y      (half_y[j*HALF_W +: HALF_W]),
            .ovf    (half_ovf[j])
        );
    end

    always_comb begin
        unique case (mode_e)
            LM_BYTE: begin
                next_y   = byte_y;
                next_ovf = byte_ovf;
            end
            LM_HALF: begin
                next_y   = half_y;
                next_ovf = BYTE_LANES'(half_ovf);
            end
        endcase
    end

    // Sequencer: state register
    always_comb begin
        unique case (state_q)
            S_IDLE:   state_d = in_valid ? S_RESULT : S_IDLE;
            S_RESULT: state_d = in_valid ? S_RESULT : S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result     <= '0;
            ovf_mask   <= '0;
            sticky_ovf <= 1'b0;
        end else begin
            if (in_valid) begin
                result   <= next_y;
                ovf_mask <= next_ovf;
            end
            sticky_ovf <= (sticky_clr ? 1'b0 : sticky_ovf)
                        | (in_valid && (|next_ovf));
        end
    end

    assign res_valid = (state_q == S_RESULT);

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid) else $error("latency"); // R1
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && $stable(result) && $stable(ovf_mask))) else $error("hold"); // R1
    AST_HALF_MASK_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode) |=> ((ovf_mask >> HALF_LANES) == '0)) else $error("half mask"); // R5
    AST_HALF_ADD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode && sat_en && op_sel == 2'b00) |=>
        (!ovf_mask[0] || result[HALF_W-1:0] == 16'h7FFF || result[HALF_W-1:0] == 16'h8000))
        else $error("clamp"); // R5
    AST_SHR_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b11) |=> (ovf_mask == '0)) else $error("shr ovf"); // R7
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && |ovf_mask) |-> sticky_ovf) else $error("sticky set"); // R9
    AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_clr && !in_valid) |=> !sticky_ovf) else $error("sticky clr"); // R9
endmodule

// File: tb/tb_simd_satalu.sv
module tb_simd_satalu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        lane_mode = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic        sat_en = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        sticky_clr = 1'b0;
    logic        res_valid;
    logic [31:0] result;
    logic [3:0]  ovf_mask;
    logic        sticky_ovf;

    int n_checks = 0;
    int n_fail = 0;
    logic exp_sticky = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    simd_satalu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_mode(lane_mode),
        .op_sel(op_sel), .sat_en(sat_en), .opa(opa), .opb(opb),
        .sticky_clr(sticky_clr), .res_valid(res_valid), .result(result),
        .ovf_mask(ovf_mask), .sticky_ovf(sticky_ovf)
    );

    function automatic logic [35:0] model(input logic mode, input logic [1:0] op,
                                          input logic sat, input logic [31:0] a,
                                          input logic [31:0] b);
        logic [31:0] y = '0;
        logic [3:0]  m = '0;
        if (!mode) begin
            for (int i = 0; i < 4; i++) begin
                int x = int'(a[8*i +: 8]);
                int v = int'(b[8*i +: 8]);
                int n = int'(b[2:0]);
                int r;
                case (op)
                    2'b00: r = x + v;
                    2'b01: r = x - v;
                    2'b10: r = x * (1 << n);
                    default: r = x / (1 << n);
                endcase
                m[i] = (r < 0) || (r > 255);
                if (m[i] && sat) y[8*i +: 8] = (r < 0) ? 8'h00 : 8'hFF;
                else             y[8*i +: 8] = r[7:0];
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                int x = int'($signed(a[16*i +: 16]));
                int v = int'($signed(b[16*i +: 16]));
                int n = int'(b[3:0]);
                int r;
                case (op)
                    2'b00: r = x + v;
                    2'b01: r = x - v;
                    2'b10: r = x * (1 << n);
                    default: r = x >>> n;
                endcase
                m[i] = (r > 32767) || (r < -32768);
                if (m[i] && sat) y[16*i +: 16] = (r < 0) ? 16'h8000 : 16'h7FFF;
                else             y[16*i +: 16] = r[15:0];
            end
        end
        return {m, y};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one operation at a falling edge; sample at the next falling edge.
    task automatic run_op(input string req, input logic mode, input logic [1:0] op,
                          input logic sat, input logic [31:0] a, input logic [31:0] b,
                          input logic clr);
        logic [35:0] e;
        e = model(mode, op, sat, a, b);
        @(negedge clk);
        in_valid = 1'b1; lane_mode = mode; op_sel = op; sat_en = sat;
        opa = a; opb = b; sticky_clr = clr;
        @(negedge clk);
        in_valid = 1'b0; sticky_clr = 1'b0;
        exp_sticky = (clr ? 1'b0 : exp_sticky) | (|e[35:32]);
        check(req, "result", result, e[31:0]);
        check(req, "mask", {28'b0, ovf_mask}, {28'b0, e[35:32]});
        check("R1", "res_valid", {31'b0, res_valid}, 32'd1);
        check("R9", "sticky", {31'b0, sticky_ovf}, {31'b0, exp_sticky});
    endtask

    task automatic t_reset();
        check("R2", "reset result", result, 32'h0);
        check("R2", "reset mask", {28'b0, ovf_mask}, 32'h0);
        check("R2", "reset valid", {31'b0, res_valid}, 32'h0);
        check("R2", "reset sticky", {31'b0, sticky_ovf}, 32'h0);
    endtask

    task automatic t_byte_add();
        run_op("R3", 1'b0, 2'b00, 1'b1, 32'hF07F0180, 32'h2001FF80, 1'b0);
        check("R3", "literal sat", result, 32'hFF80FFFF);
        check("R3", "literal mask", {28'b0, ovf_mask}, 32'h0000000B);
        run_op("R3", 1'b0, 2'b00, 1'b0, 32'h00FF00FF, 32'h00010001, 1'b0);
        check("R3", "no carry across lanes", result, 32'h00000000);
        run_op("R3", 1'b0, 2'b00, 1'b1, 32'h12345678, 32'h11111111, 1'b0);
    endtask

    task automatic t_byte_sub();
        run_op("R4", 1'b0, 2'b01, 1'b1, 32'h10FF0005, 32'h20010106, 1'b0);
        check("R4", "literal floor", result, 32'h00FE0000);
        run_op("R4", 1'b0, 2'b01, 1'b0, 32'h00000100, 32'h00000001, 1'b0);
        check("R4", "no borrow across lanes", result, 32'h000001FF);
    endtask

    task automatic t_half();
        run_op("R5", 1'b1, 2'b00, 1'b1, 32'h7FFF8000, 32'h0001FFFF, 1'b0);
        check("R5", "literal clamp", result, 32'h7FFF8000);
        check("R5", "literal mask", {28'b0, ovf_mask}, 32'h3);
        run_op("R5", 1'b1, 2'b01, 1'b1, 32'h80007FFF, 32'h0001FFFF, 1'b0);
        run_op("R5", 1'b1, 2'b01, 1'b1, 32'h12340100, 32'h03000200, 1'b0);
        run_op("R5", 1'b1, 2'b00, 1'b1, 32'hC000C000, 32'hC0004000, 1'b0);
    endtask

    task automatic t_shl();
        run_op("R6", 1'b0, 2'b10, 1'b1, 32'h01804003, 32'h00000001, 1'b0);
        run_op("R6", 1'b0, 2'b10, 1'b1, 32'h0F011002, 32'h00000007, 1'b0);
        run_op("R6", 1'b1, 2'b10, 1'b1, 32'hF0000400, 32'h00000005, 1'b0);
        check("R6", "literal q15 shl", result, 32'h80007FFF);
        run_op("R6", 1'b1, 2'b10, 1'b1, 32'hFFFF0001, 32'h0000000F, 1'b0);
        check("R6", "edge shift 15", result, 32'h80007FFF);
    endtask

    task automatic t_shr();
        run_op("R7", 1'b0, 2'b11, 1'b1, 32'h80FF7F01, 32'h00000003, 1'b0);
        check("R7", "zero fill", result, 32'h101F0F00);
        run_op("R7", 1'b1, 2'b11, 1'b1, 32'h80007FFF, 32'h00000004, 1'b0);
        check("R7", "sign fill", result, 32'hF80007FF);
    endtask

    task automatic t_wrap();
        run_op("R8", 1'b1, 2'b00, 1'b0, 32'h7FFF8000, 32'h0001FFFF, 1'b0);
        check("R8", "q15 wrap", result, 32'h80007FFF);
        run_op("R8", 1'b0, 2'b10, 1'b0, 32'hC0C0C0C0, 32'h00000002, 1'b0);
        run_op("R8", 1'b1, 2'b10, 1'b0, 32'h40000001, 32'h00000001, 1'b0);
    endtask

    task automatic t_sticky();
        // clear alone
        @(negedge clk); sticky_clr = 1'b1;
        @(negedge clk); sticky_clr = 1'b0; exp_sticky = 1'b0;
        check("R9", "clear alone", {31'b0, sticky_ovf}, 32'h0);
        // clear together with an overflow: stays set
        run_op("R9", 1'b0, 2'b00, 1'b1, 32'h000000FF, 32'h00000001, 1'b1);
        // clear together with a clean op: drops
        run_op("R9", 1'b0, 2'b00, 1'b1, 32'h00000001, 32'h00000001, 1'b1);
        // set holds over idle cycles
        run_op("R9", 1'b1, 2'b01, 1'b1, 32'h00008000, 32'h00000001, 1'b0);
        repeat (3) @(negedge clk);
        check("R9", "sticky hold", {31'b0, sticky_ovf}, 32'h1);
    endtask

    task automatic t_hold();
        logic [31:0] r0;
        logic [3:0]  m0;
        run_op("R1", 1'b0, 2'b00, 1'b1, 32'hFFFFFFFF, 32'h01010101, 1'b0);
        r0 = result; m0 = ovf_mask;
        @(negedge clk);
        opa = 32'h0; opb = 32'h0; lane_mode = 1'b1; op_sel = 2'b01;
        @(negedge clk);
        check("R1", "hold result", result, r0);
        check("R1", "hold mask", {28'b0, ovf_mask}, {28'b0, m0});
        check("R1", "valid low", {31'b0, res_valid}, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1;
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_byte_add();
        t_byte_sub();
        t_half();
        t_shl();
        t_shr();
        t_wrap();
        t_sticky();
        t_hold();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end
endmodule